// File: doc/BRIEF.md
# I2C Slave Byte Memory

This block is a two-wire serial slave wrapped around an on-chip store of 2,048 bytes. A bus master opens a transaction with a Start condition and sends a device byte. The upper nibble of that byte must match the fixed device code, three of its bits choose a segment, and its lowest bit gives the direction. The slave acknowledges every byte it accepts. In a write, the next byte sets the row. The segment and the row together form an 11-bit byte pointer, and every later byte is stored there at once, with the pointer moving up by one after each byte.

In a read, the slave shifts out the byte at the pointer, most significant bit first. It goes on to the next byte for as long as the master acknowledges. A write costs no more than the time it takes to shift the byte in, so the slave never needs to be polled for readiness. A read right after a write is served at once. A Start that arrives without a Stop before it keeps the pointer, so a short write of the address followed by a read gives random access.

Both bus lines are sampled by a faster system clock through two-flop synchronisers. The slave only ever pulls SDA low and never touches SCL.

Top module: `i2c_byte_mem`

## Requirements
- R1: After synchronous reset the slave is idle and `sda_pull_low` is 0.
- R2: A Start (SDA falls while SCL is high) begins device-byte reception from any state. A Stop (SDA rises while SCL is high) returns the slave to idle with SDA released.
- R3: A device byte whose bits [7:4] differ from 4'b1010 is not acknowledged. The bytes that follow it are neither acknowledged nor stored until the next Start.
- R4: A device byte with bit 0 = 0 opens a write. Its bits [3:1] become the segment, and the next byte becomes the row. The pointer is {segment, row}, segment in bits [10:8], and both bytes are acknowledged (SDA low on the ninth clock).
- R5: Each byte after the row byte in a write is stored at the pointer and acknowledged, and then the pointer advances by one.
- R6: The pointer wraps from 2,047 to 0, in both writes and reads.
- R7: A device byte with bit 0 = 1 opens a read. The slave sends the byte at the pointer MSB first and then advances the pointer.
- R8: While the master acknowledges, the slave goes on sending sequential bytes. On a master non-acknowledge it releases SDA and stays idle until the next Start.
- R9: A repeated Start keeps the pointer, so a write of segment and row, then a repeated Start with a read, returns the byte at that address.
- R10: The slave changes its SDA drive only while SCL is low. It drives low only in its acknowledge bits and in read bits whose value is 0.
- R11: A byte written in one transaction can be read back in the very next transaction, with no wait and no withheld acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line (wired-AND value) |
| sda_pull_low | output | 1 | 1 enables the open-drain pull-down on SDA |

## Verification
The assertions assume that the master is well behaved. SDA moves while SCL is high only to form a Start or a Stop. Each SCL level lasts much longer than the few system clocks the synchronisers and edge detectors take. Under these conditions a Start never coincides with the slave pulling SDA low, and a drive change always falls in an SCL-low phase. The bench master holds every quarter bit for ten system clocks. It changes SDA only a full quarter after SCL has fallen, and it samples SDA in the middle of the SCL-high phase, so the input never leaves that envelope.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    localparam int SEG_W   = 3;
    localparam int ROW_W   = 8;
    localparam int ADDR_W  = SEG_W + ROW_W;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ROW,
        ST_WR,
        ST_ACK,
        ST_RD,
        ST_MACK
    } slv_state_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
        byte_t data;
    } wr_req_t;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_evt_t;

    function automatic logic is_ours(input byte_t b);
        return b[7:4] == DEV_CODE;
    endfunction

    function automatic addr_t addr_next(input addr_t a);
        return addr_t'(a + 1'b1);
    endfunction

endpackage

// File: rtl/i2cmem_sync.sv
module i2cmem_sync
    import i2cmem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    output line_evt_t evt
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b1;
        else     last <= chain[STAGES-1];
    end

    always_comb begin
        evt.level = chain[STAGES-1];
        evt.rise  = chain[STAGES-1] & ~last;
        evt.fall  = ~chain[STAGES-1] & last;
    end
endmodule

// File: rtl/i2cmem_array.sv
module i2cmem_array
    import i2cmem_pkg::*;
(
    input  logic    clk,
    input  wr_req_t wr,
    input  addr_t   rd_addr,
    output byte_t   rd_data
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr.en) mem[wr.addr] <= wr.data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
    import i2cmem_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_evt_t scl,
    input  line_evt_t sda,
    input  byte_t     rd_data,
    output addr_t     ptr,
    output wr_req_t   wr,
    output logic      sda_low
);
    slv_state_t            state, after_ack;
    logic [CNT_W-1:0]      cnt;
    byte_t                 shreg, txreg;
    logic [SEG_W-1:0]      seg_pend;
    logic                  mack_seen;
    logic                  start_ev, stop_ev, byte_done;

    assign start_ev  = sda.fall & scl.level;
    assign stop_ev   = sda.rise & scl.level;
    assign byte_done = scl.fall && (cnt == CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            txreg     <= '0;
            seg_pend  <= '0;
            mack_seen <= 1'b0;
            ptr       <= '0;
            sda_low   <= 1'b0;
            wr        <= '0;
        end else begin
            wr.en <= 1'b0;
            if (start_ev) begin
                state   <= ST_DEV;
                cnt     <= '0;
                sda_low <= 1'b0;
            end else if (stop_ev) begin
                state   <= ST_IDLE;
                cnt     <= '0;
                sda_low <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_ROW, ST_WR: begin
                        if (scl.rise && cnt != CNT_W'(BYTE_W)) begin
                            shreg <= {shreg[BYTE_W-2:0], sda.level};
                            cnt   <= cnt + 1'b1;
                        end else if (byte_done) begin
                            cnt <= '0;
                            if (state == ST_DEV) begin
                                if (is_ours(shreg)) begin
                                    sda_low <= 1'b1;
                                    state   <= ST_ACK;
                                    if (shreg[0]) begin
                                        after_ack <= ST_RD;
                                    end else begin
                                        after_ack <= ST_ROW;
                                        seg_pend  <= shreg[SEG_W:1];
                                    end
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_ROW) begin
                                ptr       <= {seg_pend, shreg};
                                sda_low   <= 1'b1;
                                state     <= ST_ACK;
                                after_ack <= ST_WR;
                            end else begin
                                wr.en     <= 1'b1;
                                wr.addr   <= ptr;
                                wr.data   <= shreg;
                                ptr       <= addr_next(ptr);
                                sda_low   <= 1'b1;
                                state     <= ST_ACK;
                                after_ack <= ST_WR;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl.fall) begin
                            cnt <= '0;
                            if (after_ack == ST_RD) begin
                                txreg   <= rd_data;
                                sda_low <= ~rd_data[BYTE_W-1];
                                ptr     <= addr_next(ptr);
                                state   <= ST_RD;
                            end else begin
                                sda_low <= 1'b0;
                                state   <= after_ack;
                            end
                        end
                    end
                    ST_RD: begin
                        if (scl.rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (byte_done) begin
                            cnt       <= '0;
                            sda_low   <= 1'b0;
                            mack_seen <= 1'b0;
                            state     <= ST_MACK;
                        end else if (scl.fall) begin
                            txreg   <= {txreg[BYTE_W-2:0], 1'b0};
                            sda_low <= ~txreg[BYTE_W-2];
                        end
                    end
                    ST_MACK: begin
                        if (scl.rise) begin
                            mack_seen <= ~sda.level;
                        end else if (scl.fall) begin
                            if (mack_seen) begin
                                txreg   <= rd_data;
                                sda_low <= ~rd_data[BYTE_W-1];
                                ptr     <= addr_next(ptr);
                                cnt     <= '0;
                                state   <= ST_RD;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_low <= 1'b0;
                    end
                endcase
            end
        end
    end

    AST_RST_RELEASED: assert property (@(posedge clk) $fell(rst) |-> !sda_low && state == ST_IDLE); // R1
    AST_START_TO_DEV: assert property (@(posedge clk) disable iff (rst) start_ev |=> state == ST_DEV && !sda_low); // R2
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst) (stop_ev && !start_ev) |=> state == ST_IDLE && !sda_low); // R2
    AST_FOREIGN_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEV && byte_done && !is_ours(shreg) && !start_ev && !stop_ev) |=> state == ST_IDLE && !sda_low); // R3
    AST_WRITE_ADVANCES: assert property (@(posedge clk) disable iff (rst) wr.en |-> ptr == addr_next(wr.addr)); // R6
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst) state == ST_IDLE |-> !sda_low); // R8
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst) !$stable(sda_low) |-> !scl.level); // R10
    AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(BYTE_W)); // R10
endmodule

// File: rtl/i2c_byte_mem.sv
module i2c_byte_mem
    import i2cmem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull_low
);
    line_evt_t scl_evt, sda_evt;
    addr_t     ptr;
    byte_t     rd_data;
    wr_req_t   wr;

    i2cmem_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .din(scl_in), .evt(scl_evt)
    );

    i2cmem_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .din(sda_in), .evt(sda_evt)
    );

    i2cmem_ctrl u_ctrl (
        .clk(clk), .rst(rst), .scl(scl_evt), .sda(sda_evt),
        .rd_data(rd_data), .ptr(ptr), .wr(wr), .sda_low(sda_pull_low)
    );

    i2cmem_array u_array (
        .clk(clk), .wr(wr), .rd_addr(ptr), .rd_data(rd_data)
    );
endmodule

// File: tb/i2c_byte_mem_test.sv
module i2c_byte_mem_test;
    localparam int Q = 10;
    localparam int NVEC = 8;
    localparam int WATCHDOG = 190000;
    // each entry: {address[10:0], data[7:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {11'h000, 8'h5A}, {11'h7FF, 8'hC3}, {11'h123, 8'h00}, {11'h456, 8'hFF},
        {11'h3A0, 8'h81}, {11'h0FF, 8'h7E}, {11'h500, 8'h11}, {11'h6CD, 8'hE4}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull_low;
    logic sda_bus;
    int   tests = 0;
    int   fails = 0;
    int   bad_changes = 0;
    logic prev_drive = 1'b0;
    logic done = 1'b0;

    assign sda_bus = m_sda & ~sda_pull_low;

    always #10 clk = ~clk;

    i2c_byte_mem uut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_bus), .sda_pull_low(sda_pull_low)
    );

    // R10 monitor: drive changes must land while SCL is low
    always @(negedge clk) begin
        if (!rst && sda_pull_low != prev_drive && m_scl) bad_changes++;
        prev_drive <= sda_pull_low;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2 * Q);
    endtask

    task automatic tx_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q);
            m_scl = 1'b1; wq(2 * Q);
            m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        ack = ~sda_bus; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic rx_byte(output logic [7:0] b, input logic mack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            m_scl = 1'b1; wq(Q);
            b[i] = sda_bus; wq(Q);
            m_scl = 1'b0; wq(Q);
        end
        m_sda = ~mack; wq(Q);
        m_scl = 1'b1; wq(2 * Q);
        m_scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    task automatic write_at(input logic [10:0] a, input logic [7:0] d, input string req);
        logic ack;
        bus_start();
        tx_byte({4'b1010, a[10:8], 1'b0}, ack); chk({req, " dev ack"}, ack, 1);
        tx_byte(a[7:0], ack);                    chk({req, " row ack"}, ack, 1);
        tx_byte(d, ack);                         chk({req, " data ack"}, ack, 1);
        bus_stop();
    endtask

    task automatic read_at(input logic [10:0] a, output logic [7:0] d);
        logic ack;
        bus_start();
        tx_byte({4'b1010, a[10:8], 1'b0}, ack);
        tx_byte(a[7:0], ack);
        bus_start();
        tx_byte({4'b1010, 3'b000, 1'b1}, ack);
        rx_byte(d, 1'b0);
        bus_stop();
    endtask

    initial begin
        wq(WATCHDOG);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        wq(5);
        chk("R1 drive during reset", sda_pull_low, 0);
        rst = 1'b0;
        wq(3 * Q);
        chk("R1 drive after reset", sda_pull_low, 0);

        // R4 R9 R11: table walk, write then immediate random read
        for (int v = 0; v < NVEC; v++) begin
            write_at(VEC[v][18:8], VEC[v][7:0], "R4");
            read_at(VEC[v][18:8], d);
            chk("R9 R11 random read", d, VEC[v][7:0]);
        end

        // R3: foreign device code, following bytes neither acked nor stored
        bus_start();
        tx_byte(8'b1001_0010, ack); chk("R3 foreign dev nack", ack, 0);
        tx_byte(8'h23, ack);        chk("R3 later byte nack", ack, 0);
        tx_byte(8'h99, ack);        chk("R3 data nack", ack, 0);
        bus_stop();
        read_at(11'h123, d);
        chk("R3 location untouched", d, 8'h00);

        // R5 R7 R8: burst write, then sequential read with master ack
        bus_start();
        tx_byte(8'b1010_0100, ack); chk("R4 burst dev ack", ack, 1);
        tx_byte(8'h40, ack);        chk("R4 burst row ack", ack, 1);
        for (int k = 0; k < 4; k++) begin
            tx_byte(8'hA0 + k[7:0], ack); chk("R5 burst data ack", ack, 1);
        end
        bus_stop();
        bus_start();
        tx_byte(8'b1010_0100, ack);
        tx_byte(8'h40, ack);
        bus_start();
        tx_byte(8'b1010_0001, ack); chk("R7 read dev ack", ack, 1);
        for (int k = 0; k < 4; k++) begin
            rx_byte(d, k != 3);
            chk("R7 R8 sequential read", d, 8'hA0 + k);
        end
        wq(Q);
        chk("R8 released after nack", sda_pull_low, 0);
        // clock one more byte without Stop: slave must stay silent
        rx_byte(d, 1'b0);
        chk("R8 silent after nack", d, 8'hFF);
        bus_stop();

        // R6: wrap in a write burst
        bus_start();
        tx_byte(8'b1010_1110, ack);
        tx_byte(8'hFF, ack);
        tx_byte(8'h3C, ack);
        tx_byte(8'h4D, ack); chk("R6 wrap write ack", ack, 1);
        bus_stop();
        read_at(11'h000, d);
        chk("R6 wrapped write lands at 0", d, 8'h4D);

        // R6: wrap in a read burst
        bus_start();
        tx_byte(8'b1010_1110, ack);
        tx_byte(8'hFF, ack);
        bus_start();
        tx_byte(8'b1010_0001, ack);
        rx_byte(d, 1'b1); chk("R6 read at 2047", d, 8'h3C);
        rx_byte(d, 1'b0); chk("R6 read wraps to 0", d, 8'h4D);
        bus_stop();

        // R2: Start in mid-byte aborts and restarts reception
        bus_start();
        for (int i = 0; i < 3; i++) begin
            m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
        end
        bus_start();
        tx_byte(8'b1010_0000, ack); chk("R2 restart dev ack", ack, 1);
        bus_stop();
        wq(Q);
        chk("R2 released after stop", sda_pull_low, 0);

        chk("R10 drive changes while SCL high", bad_changes, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule